// File: doc/BRIEF.md
# Quadrature Position Counter with Edge Mask

This block turns pairs of quadrature phase signals into signed-style 16-bit position counts, one count per channel. Each step of the two-bit Gray sequence moves the count by one, up for one rotation sense and down for the other. Phase inputs are resynchronised to the system clock. They are then evaluated only on ticks from one of sixteen sampling sources, chosen per channel.

Software can suppress any of the eight individual phase steps through a mask. Wrap-around of the count in either direction latches a status flag that stays set until software writes a one to it, and enabled flags drive a shared interrupt line. A hold bit freezes the value that software reads while counting goes on underneath. Register access is a flat, single-cycle write bus with a combinational read port. Address bit 3 selects the channel and bits 2:0 select the register.

Top module: `quad_enc_counter`

## Requirements
- R1: After reset every count, status flag, interrupt enable, mode field and clock select reads as zero and `irq` is low.
- R2: With state written {A,B}, the steps 00→01, 01→11, 11→10 and 10→00 add one to the count (mask bits 0,1,2,3 in that order). The steps 01→00, 11→01, 10→11 and 00→10 subtract one (mask bits 4,5,6,7 in that order).
- R3: A sample in which both phases change, or in which neither changes, leaves the count unchanged, and the count moves by at most one per clock.
- R4: A mask bit set to 1 (mode register, index 0, bits 15:8) stops its step from counting. The sampled phase state still advances, so the step after it decodes normally.
- R5: An up-count from 0xFFFF to 0x0000 sets the positive wrap flag (status register, index 3, bit 0).
- R6: A down-count from 0x0000 to 0xFFFF sets the negative wrap flag (status register, index 3, bit 1).
- R7: Wrap flags stay set until a write to the status register with a 1 in their bit position, and a 0 leaves them unchanged. A wrap in the same cycle as a clearing write leaves that flag set.
- R8: While hold (mode bit 1) is 1, the value register (index 2) keeps its last value while the count still moves. After hold returns to 0, it shows the live count again.
- R9: While enable (mode bit 0) is 0, the count does not change.
- R10: Phases are evaluated only in clock cycles where the sampling source chosen by the 4-bit select (index 1, bits 3:0) is high. A step made between ticks is counted at the next tick.
- R11: `irq` is high exactly when some wrap flag is set whose bit in the interrupt enable register (index 4, bits 1:0) is 1.
- R12: Phase inputs pass a two-flop synchroniser, and one channel's phases, mode and status never affect another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_src | input | 16 | Candidate sampling strobes |
| ph_a | input | 2 | Phase A per channel |
| ph_b | input | 2 | Phase B per channel |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | {channel, register index} |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrap event and a software clearing write can arrive in the same clock. The bench parks the channel's sampling on a source held low and moves the phases so that a step is pending with the count at 0xFFFF, and later at 0x0000. It then pulses that source in the very cycle it issues a write of ones to the status register. The result is correct when the flag for the wrap that just happened reads as 1 and the other flag reads as 0, with the count already wrapped.

// File: rtl/quad_enc_counter.sv
module quad_enc_counter #(
  parameter int NCH  = 2,
  parameter int CW   = 16,
  parameter int NSRC = 16,
  localparam int SELW = $clog2(NSRC),
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW   = CHW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] tick_src,
  input  logic [NCH-1:0]  ph_a,
  input  logic [NCH-1:0]  ph_b,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [15:0]     bus_wdata,
  output logic [15:0]     bus_rdata,
  output logic            irq
);

  logic [NCH-1:0][1:0]      sy1_q, sy2_q, prv_q;
  logic [NCH-1:0]           en_q, hold_q;
  logic [NCH-1:0][7:0]      msk_q;
  logic [NCH-1:0][SELW-1:0] sel_q;
  logic [NCH-1:0][CW-1:0]   cnt_q, vis_q;
  logic [NCH-1:0][1:0]      st_q, ie_q;
  logic [NCH-1:0]           tk, up, dn;
  logic [NCH-1:0][7:0]      hit;
  logic [NCH-1:0]           wr_mode, wr_sel, wr_st, wr_ie;
  logic                     unused_bits;

  assign unused_bits = ^bus_wdata;

  function automatic logic [7:0] trans_code(input logic [1:0] p, input logic [1:0] n);
    case ({p, n})
      4'b0001: trans_code = 8'h01;
      4'b0111: trans_code = 8'h02;
      4'b1110: trans_code = 8'h04;
      4'b1000: trans_code = 8'h08;
      4'b0100: trans_code = 8'h10;
      4'b1101: trans_code = 8'h20;
      4'b1011: trans_code = 8'h40;
      4'b0010: trans_code = 8'h80;
      default: trans_code = 8'h00;
    endcase
  endfunction

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      tk[c]      = tick_src[sel_q[c]];
      hit[c]     = trans_code(prv_q[c], sy2_q[c]) & ~msk_q[c];
      up[c]      = tk[c] & en_q[c] & (|hit[c][3:0]);
      dn[c]      = tk[c] & en_q[c] & (|hit[c][7:4]);
      wr_mode[c] = bus_wr && bus_addr[AW-1:3] == CHW'(c) && bus_addr[2:0] == 3'd0;
      wr_sel[c]  = bus_wr && bus_addr[AW-1:3] == CHW'(c) && bus_addr[2:0] == 3'd1;
      wr_st[c]   = bus_wr && bus_addr[AW-1:3] == CHW'(c) && bus_addr[2:0] == 3'd3;
      wr_ie[c]   = bus_wr && bus_addr[AW-1:3] == CHW'(c) && bus_addr[2:0] == 3'd4;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1_q  <= '0;
      sy2_q  <= '0;
      prv_q  <= '0;
      en_q   <= '0;
      hold_q <= '0;
      msk_q  <= '0;
      sel_q  <= '0;
      cnt_q  <= '0;
      vis_q  <= '0;
      st_q   <= '0;
      ie_q   <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        sy1_q[c] <= {ph_a[c], ph_b[c]};
        sy2_q[c] <= sy1_q[c];
        if (tk[c]) prv_q[c] <= sy2_q[c];
        if (up[c])      cnt_q[c] <= cnt_q[c] + 1'b1;
        else if (dn[c]) cnt_q[c] <= cnt_q[c] - 1'b1;
        st_q[c] <= (st_q[c] & ~(wr_st[c] ? bus_wdata[1:0] : 2'b00))
                 | {dn[c] && cnt_q[c] == '0, up[c] && cnt_q[c] == '1};
        if (!hold_q[c]) vis_q[c] <= cnt_q[c];
        if (wr_mode[c]) begin
          msk_q[c]  <= bus_wdata[15:8];
          hold_q[c] <= bus_wdata[1];
          en_q[c]   <= bus_wdata[0];
        end
        if (wr_sel[c]) sel_q[c] <= bus_wdata[SELW-1:0];
        if (wr_ie[c])  ie_q[c]  <= bus_wdata[1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr[AW-1:3] == CHW'(c)) begin
        case (bus_addr[2:0])
          3'd0: bus_rdata = {msk_q[c], 6'b0, hold_q[c], en_q[c]};
          3'd1: bus_rdata[SELW-1:0] = sel_q[c];
          3'd2: bus_rdata[CW-1:0] = vis_q[c];
          3'd3: bus_rdata[1:0] = st_q[c];
          3'd4: bus_rdata[1:0] = ie_q[c];
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  assign irq = |(st_q & ie_q);

endmodule

// File: rtl/quad_enc_counter_chk.sv
module quad_enc_counter_chk #(
  parameter int NCH = 2,
  parameter int CW  = 16,
  parameter int CHW = 1,
  parameter int AW  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [AW-1:0]          bus_addr,
  input logic [15:0]            bus_wdata,
  input logic [NCH-1:0][CW-1:0] cnt_q,
  input logic [NCH-1:0][CW-1:0] vis_q,
  input logic [NCH-1:0][1:0]    st_q,
  input logic [NCH-1:0]         en_q,
  input logic [NCH-1:0]         hold_q,
  input logic                   irq
);

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (st_q == '0) |-> !irq); // R11

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic clr_st;
    assign clr_st = bus_wr && bus_addr == {CHW'(g), 3'd3};

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt_q[g]) == {CW{1'b1}} && cnt_q[g] == '0) |-> st_q[g][0]); // R5
    AST_DN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt_q[g]) == '0 && cnt_q[g] == {CW{1'b1}}) |-> st_q[g][1]); // R6
    AST_POS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q[g][0]) && !($past(clr_st) && $past(bus_wdata[0]))) |-> st_q[g][0]); // R7
    AST_NEG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q[g][1]) && !($past(clr_st) && $past(bus_wdata[1]))) |-> st_q[g][1]); // R7
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[g] == $past(cnt_q[g]) || cnt_q[g] == $past(cnt_q[g]) + 1'b1
       || cnt_q[g] == $past(cnt_q[g]) - 1'b1)); // R3
    AST_OFF_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_q[g]) |-> $stable(cnt_q[g])); // R9
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hold_q[g]) |-> $stable(vis_q[g])); // R8
  end

endmodule

bind quad_enc_counter quad_enc_counter_chk #(.NCH(NCH), .CW(CW), .CHW(CHW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .cnt_q(cnt_q), .vis_q(vis_q), .st_q(st_q), .en_q(en_q), .hold_q(hold_q), .irq(irq)
);

// File: tb/sim_quad_enc_counter.sv
module sim_quad_enc_counter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [15:0] tsrc;
  logic [1:0]  pa, pb;
  logic        bw;
  logic [3:0]  ba;
  logic [15:0] bwd;
  wire  [15:0] brd;
  wire         irq;

  int total = 0, bad = 0;
  bit done = 0;

  logic [15:0] mcnt[2], mheld[2];
  logic [1:0]  mst[2], mprv[2], mcur[2], mie[2];
  logic [7:0]  mmsk[2];
  logic        men[2], mhold[2], mtk[2];

  quad_enc_counter u0 (
    .clk(clk), .rst_n(rst_n), .tick_src(tsrc), .ph_a(pa), .ph_b(pb),
    .bus_wr(bw), .bus_addr(ba), .bus_wdata(bwd), .bus_rdata(brd), .irq(irq)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int ch, int idx, logic [15:0] d);
    @(posedge clk); #1;
    bw = 1'b1; ba = {ch[0], idx[2:0]}; bwd = d;
    @(posedge clk); #1;
    bw = 1'b0;
  endtask

  task automatic rd(int ch, int idx, output logic [15:0] v);
    @(posedge clk); #1;
    ba = {ch[0], idx[2:0]};
    @(negedge clk);
    v = brd;
  endtask

  task automatic set_mode(int ch);
    wr(ch, 0, {mmsk[ch], 6'b0, mhold[ch], men[ch]});
  endtask

  function automatic int gpos(logic [1:0] s);
    case (s)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic model_tick(int ch);
    int p, n;
    p = gpos(mprv[ch]);
    n = gpos(mcur[ch]);
    if (men[ch]) begin
      if (n == (p + 1) % 4 && !mmsk[ch][p]) begin
        if (mcnt[ch] == 16'hFFFF) mst[ch][0] = 1'b1;
        mcnt[ch] = mcnt[ch] + 16'd1;
      end else if (n == (p + 3) % 4 && !mmsk[ch][4 + n]) begin
        if (mcnt[ch] == 16'h0000) mst[ch][1] = 1'b1;
        mcnt[ch] = mcnt[ch] - 16'd1;
      end
    end
    mprv[ch] = mcur[ch];
  endtask

  task automatic verify(int ch, string tag);
    logic [15:0] v;
    logic expirq;
    rd(ch, 2, v);
    chk({tag, " value"}, v, mhold[ch] ? mheld[ch] : mcnt[ch]);
    rd(ch, 3, v);
    chk({tag, " status"}, v, {14'b0, mst[ch]});
    expirq = |(mst[0] & mie[0]) | |(mst[1] & mie[1]);
    chk({tag, " irq R11"}, {15'b0, irq}, {15'b0, expirq});
  endtask

  task automatic step(int ch, logic [1:0] ns, string tag);
    @(posedge clk); #1;
    pa[ch] = ns[1]; pb[ch] = ns[0];
    mcur[ch] = ns;
    repeat (5) @(posedge clk);
    if (mtk[ch]) model_tick(ch);
    verify(ch, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bw = 1'b0; ba = '0; bwd = '0; tsrc = 16'h0001; pa = '0; pb = '0;
    for (int c = 0; c < 2; c++) begin
      mcnt[c] = '0; mheld[c] = '0; mst[c] = '0; mprv[c] = '0; mcur[c] = '0; mie[c] = '0;
      mmsk[c] = '0; men[c] = 1'b0; mhold[c] = 1'b0; mtk[c] = 1'b1;
    end
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0] masks[12];
    masks[0] = 8'h00; masks[1] = 8'hFF; masks[2] = 8'h0F; masks[3] = 8'hF0;
    for (int i = 0; i < 8; i++) masks[4 + i] = 8'(1 << i);

    do_reset();
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 5; k++) begin
        rd(c, k, v);
        chk("R1 reset register", v, 16'h0000);
      end
    end
    chk("R1 reset irq", {15'b0, irq}, 16'h0000);

    men[0] = 1'b1; set_mode(0);
    men[1] = 1'b1; set_mode(1);
    mie[0] = 2'b01; wr(0, 4, 16'h0001);

    // R2 R3 R4 R5 R6: every ordered state pair under each mask, channel 0
    foreach (masks[m]) begin
      mmsk[0] = masks[m]; set_mode(0);
      for (int p = 0; p < 4; p++)
        for (int n = 0; n < 4; n++) begin
          step(0, 2'(p), "R2_R4_R5_R6 from");
          step(0, 2'(n), "R2_R3_R4 to");
        end
      wr(0, 3, 16'h0000);
      verify(0, "R7 zero write");
      rd(1, 2, v);
      chk("R12 idle channel value", v, mcnt[1]);
      wr(0, 3, 16'h0003); mst[0] = 2'b00;
      verify(0, "R7 clear");
    end

    // R12: channel 1 sweep, channel 0 untouched
    mie[1] = 2'b10; wr(1, 4, 16'h0002);
    for (int m = 0; m < 2; m++) begin
      mmsk[1] = (m == 0) ? 8'h00 : 8'h3C; set_mode(1);
      for (int p = 0; p < 4; p++)
        for (int n = 0; n < 4; n++) begin
          step(1, 2'(p), "R12 ch1 from");
          step(1, 2'(n), "R12 ch1 to");
        end
      verify(0, "R12 ch0 unaffected");
    end

    // R11: enables masked off while flags set
    mie[1] = 2'b00; wr(1, 4, 16'h0000);
    verify(1, "R11 enable off");

    // R8: hold
    mmsk[0] = 8'h00; mhold[0] = 1'b1; set_mode(0);
    repeat (2) @(posedge clk);
    mheld[0] = mcnt[0];
    for (int i = 0; i < 6; i++) step(0, 2'(gpos(mcur[0]) == 0 ? 1 : gpos(mcur[0]) == 1 ? 3 :
                                          gpos(mcur[0]) == 2 ? 2 : 0), "R8 held");
    mhold[0] = 1'b0; set_mode(0);
    repeat (2) @(posedge clk);
    verify(0, "R8 released");

    // R9: disable
    men[0] = 1'b0; set_mode(0);
    step(0, 2'b01, "R9 off");
    step(0, 2'b11, "R9 off");
    step(0, 2'b01, "R9 off");
    men[0] = 1'b1; set_mode(0);
    step(0, 2'b11, "R9 on");

    // R10: sampling source select
    wr(0, 1, 16'h0005); mtk[0] = 1'b0;
    step(0, 2'b10, "R10 no tick");
    @(posedge clk); #1; tsrc[5] = 1'b1;
    @(posedge clk); #1; tsrc[5] = 1'b0;
    model_tick(0);
    verify(0, "R10 tick");
    wr(0, 1, 16'h0000); mtk[0] = 1'b1;
    step(0, 2'b00, "R10 source 0");

    // R7: wrap and clearing write in the same cycle
    do_reset();
    men[0] = 1'b1; set_mode(0);
    step(0, 2'b10, "R6 down wrap");
    wr(0, 1, 16'h0005); mtk[0] = 1'b0;
    step(0, 2'b00, "R10 pending up");
    @(posedge clk); #1;
    bw = 1'b1; ba = 4'h3; bwd = 16'h0003; tsrc[5] = 1'b1;
    @(posedge clk); #1;
    bw = 1'b0; tsrc[5] = 1'b0;
    mst[0] = 2'b00; model_tick(0);
    verify(0, "R7 same-cycle pos");
    step(0, 2'b10, "R10 pending down");
    @(posedge clk); #1;
    bw = 1'b1; ba = 4'h3; bwd = 16'h0003; tsrc[5] = 1'b1;
    @(posedge clk); #1;
    bw = 1'b0; tsrc[5] = 1'b0;
    mst[0] = 2'b00; model_tick(0);
    verify(0, "R7 same-cycle neg");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule